// File: doc/BRIEF.md
# Nibble-Bus Dual-Register Slave

This block is the slave end of a 4-bit I/O bus. It holds a small set of peripheral register units and one redirect switch. Each unit answers at its own bus address. A plain write or read to that address reaches the unit's primary register. A unit may also have an auxiliary register, either one nibble or one byte wide. Software reaches the auxiliary register in two steps. It first writes the unit's address as data to the switch address. The access to that unit which comes next then lands in the auxiliary register instead of the primary one.

A byte-wide auxiliary register takes two consecutive nibble accesses. A write sequence carries the low nibble and then the high nibble. A read sequence returns the high nibble and then the low nibble. The redirection stays armed across both nibbles and clears after the second. The register contents are presented on flat output vectors, so that the peripheral logic around the block can use them.

The bus request is a valid/ready stream. The block never applies back-pressure, so every cycle with `bus_vld` high is one accepted access. Read data comes back one cycle after the request, marked by `rd_vld`. There is no ready on the response side, so the master must take the response in the cycle it appears.

Top module: `nibble_dualreg_slave`

## Requirements
- R1: After reset every primary register and every auxiliary register is zero, the redirection is disarmed, and `rd_vld` is low.
- R2: Unit i answers at bus address MOD_BASE+i. A write (`bus_wr`=1) with no redirection armed stores `bus_wdata` into that unit's primary register, which appears at `prim_q[4i+3:4i]`. A read (`bus_wr`=0) returns the primary register.
- R3: A write to SW_ADDR arms the redirection and holds the written nibble as the target address. A later write to the switch replaces the target. While the redirection is armed, an access to the target unit goes to its auxiliary register (`aux_q[8i+7:8i]`), and the primary register is left unchanged.
- R4: For a unit with a nibble-wide auxiliary register (`aux_q` bits 7:4 of its slice read zero), one redirected access clears the redirection. The access after it reaches the primary register again.
- R5: For a unit with a byte-wide auxiliary register, the first redirected write stores the low nibble and the second stores the high nibble. The redirection then clears.
- R6: For a unit with a byte-wide auxiliary register, the first redirected read returns the high nibble and the second returns the low nibble. The redirection then clears.
- R7: While the redirection is armed, an access to any address other than the target or SW_ADDR clears it. This includes other units and unmapped addresses. An access to another unit reaches that unit's primary register.
- R8: A unit without an auxiliary register ignores the redirection. An access to it while it is the armed target reaches its primary register and clears the redirection.
- R9: `rd_vld` rises exactly one cycle after a read of a unit address. A read of SW_ADDR or of an unmapped address gives no response. A read of SW_ADDR also leaves the redirection unchanged. `rd_data` is zero whenever `rd_vld` is low.
- R10: `bus_rdy` is always high. Back-to-back accesses in consecutive cycles are each handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Access request valid |
| bus_rdy | output | 1 | Access accepted (always high) |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Module address of the access |
| bus_wdata | input | 4 | Write data nibble |
| rd_vld | output | 1 | Read response valid, one cycle after the read |
| rd_data | output | 4 | Read response nibble, zero when idle |
| prim_q | output | 4*NMOD | Primary register of each unit, unit i at bits 4i+3:4i |
| aux_q | output | 8*NMOD | Auxiliary register of each unit, unit i at bits 8i+7:8i |

## Verification
The bench builds the block with its defaults. These are three units at addresses 1, 2 and 3, the switch at address F, the auxiliary mask 3'b110 and the byte mask 3'b100. With these values one unit has no auxiliary register, one has a nibble-wide auxiliary register and one has a byte-wide auxiliary register. All three behaviours can therefore be tested against each other in one run. Address 0 and addresses 4 to E stay unmapped, which brings the unmapped-read and cancel-by-stray-access cases within reach.

// File: rtl/ndr_pkg.sv
package ndr_pkg;
  localparam int NIB_W = 4;

  typedef logic [NIB_W-1:0] nib_t;

  typedef struct packed {
    logic armed;
    nib_t target;
    logic phase;
  } redir_t;
endpackage

// File: rtl/ndr_redirect.sv
module ndr_redirect
  import ndr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_vld,
  input  logic acc_wr,
  input  nib_t acc_addr,
  input  nib_t acc_wdata,
  input  logic sw_hit,
  input  logic tgt_aux,
  input  logic tgt_byte,
  output logic aux_sel,
  output logic nib_hi
);
  redir_t st_q, st_d;

  always_comb begin
    aux_sel = st_q.armed && (st_q.target == acc_addr) && tgt_aux && !sw_hit;
    // writes go low then high, reads go high then low
    nib_hi  = tgt_byte && (acc_wr ? st_q.phase : !st_q.phase);
    st_d    = st_q;
    if (acc_vld) begin
      if (sw_hit) begin
        if (acc_wr) begin
          st_d.armed  = 1'b1;
          st_d.target = acc_wdata;
          st_d.phase  = 1'b0;
        end
      end else if (aux_sel && tgt_byte && !st_q.phase) begin
        st_d.phase = 1'b1;
      end else begin
        st_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  // R3
  arm_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && sw_hit) |=> (st_q.armed && st_q.target == $past(acc_wdata)));

  // R7
  clear_on_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !sw_hit && !aux_sel) |=> !st_q.armed);

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && aux_sel && tgt_byte && !st_q.phase) |=> (st_q.armed && st_q.phase));

  // R4
  nibble_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && aux_sel && !tgt_byte) |=> !st_q.armed);
endmodule

// File: rtl/ndr_unit.sv
module ndr_unit
  import ndr_pkg::*;
#(
  parameter bit HAS_AUX  = 1'b1,
  parameter bit AUX_BYTE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic               aux,
  input  logic               nib_hi,
  input  nib_t               wdata,
  output nib_t               prim_q,
  output logic [2*NIB_W-1:0] aux_q,
  output nib_t               rd_nib
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 prim_q <= '0;
    else if (sel && wr && !aux) prim_q <= wdata;
  end

  generate
    if (!HAS_AUX) begin : g_single
      logic unused_ctl;
      assign unused_ctl = aux ^ nib_hi;
      assign aux_q      = '0;
      assign rd_nib     = prim_q;
    end else if (AUX_BYTE) begin : g_byte
      logic [2*NIB_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else if (sel && wr && aux) begin
          if (nib_hi) byte_q[2*NIB_W-1:NIB_W] <= wdata;
          else        byte_q[NIB_W-1:0]       <= wdata;
        end
      end
      assign aux_q  = byte_q;
      assign rd_nib = !aux ? prim_q :
                      (nib_hi ? byte_q[2*NIB_W-1:NIB_W] : byte_q[NIB_W-1:0]);

      // R5
      aux_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && aux && nib_hi) |=> (byte_q[2*NIB_W-1:NIB_W] == $past(wdata)));
    end else begin : g_nib
      nib_t lo_q;
      logic unused_hi;
      assign unused_hi = nib_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                lo_q <= '0;
        else if (sel && wr && aux) lo_q <= wdata;
      end
      assign aux_q  = {{NIB_W{1'b0}}, lo_q};
      assign rd_nib = aux ? lo_q : prim_q;
    end
  endgenerate

  // R2
  prim_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !aux) |=> (prim_q == $past(wdata)));

  // R3
  prim_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && aux) |=> $stable(prim_q));
endmodule

// File: rtl/nibble_dualreg_slave.sv
module nibble_dualreg_slave
  import ndr_pkg::*;
#(
  parameter int              NMOD      = 3,
  parameter logic [3:0]      MOD_BASE  = 4'h1,
  parameter logic [3:0]      SW_ADDR   = 4'hF,
  parameter logic [NMOD-1:0] AUX_MASK  = 3'b110,
  parameter logic [NMOD-1:0] BYTE_MASK = 3'b100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_vld,
  output logic                    bus_rdy,
  input  logic                    bus_wr,
  input  logic [NIB_W-1:0]        bus_addr,
  input  logic [NIB_W-1:0]        bus_wdata,
  output logic                    rd_vld,
  output logic [NIB_W-1:0]        rd_data,
  output logic [NIB_W*NMOD-1:0]   prim_q,
  output logic [2*NIB_W*NMOD-1:0] aux_q
);
  localparam int AUX_W = 2 * NIB_W;

  logic [NMOD-1:0] hit;
  logic            sw_hit, mapped, tgt_aux, tgt_byte;
  logic            aux_sel, nib_hi;
  nib_t            rd_all [NMOD];
  nib_t            rd_mux;

  assign bus_rdy = 1'b1;
  assign sw_hit  = (bus_addr == SW_ADDR);

  for (genvar i = 0; i < NMOD; i++) begin : g_dec
    assign hit[i] = !sw_hit && (bus_addr == nib_t'(MOD_BASE + i));
  end

  assign mapped = |hit;

  always_comb begin
    tgt_aux  = 1'b0;
    tgt_byte = 1'b0;
    rd_mux   = '0;
    for (int i = 0; i < NMOD; i++) begin
      if (hit[i]) begin
        tgt_aux  = AUX_MASK[i];
        tgt_byte = BYTE_MASK[i];
        rd_mux   = rd_all[i];
      end
    end
  end

  ndr_redirect u_redirect (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_vld  (bus_vld),
    .acc_wr   (bus_wr),
    .acc_addr (bus_addr),
    .acc_wdata(bus_wdata),
    .sw_hit   (sw_hit),
    .tgt_aux  (tgt_aux),
    .tgt_byte (tgt_byte),
    .aux_sel  (aux_sel),
    .nib_hi   (nib_hi)
  );

  for (genvar i = 0; i < NMOD; i++) begin : g_unit
    ndr_unit #(
      .HAS_AUX (AUX_MASK[i]),
      .AUX_BYTE(BYTE_MASK[i])
    ) u_unit (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (bus_vld && hit[i]),
      .wr    (bus_wr),
      .aux   (aux_sel),
      .nib_hi(nib_hi),
      .wdata (bus_wdata),
      .prim_q(prim_q[NIB_W*i +: NIB_W]),
      .aux_q (aux_q[AUX_W*i +: AUX_W]),
      .rd_nib(rd_all[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else if (bus_vld && !bus_wr && mapped) begin
      rd_vld  <= 1'b1;
      rd_data <= rd_mux;
    end else begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end
  end

  // R9
  rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(bus_vld && !bus_wr && mapped));

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> (rd_data == '0));
endmodule

// File: tb/test_nibble_dualreg_slave.sv
`timescale 1ns/1ps
module test_nibble_dualreg_slave;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_rdy, rd_vld;
  logic [3:0]  rd_data;
  logic [11:0] prim_q;
  logic [23:0] aux_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  nibble_dualreg_slave i_nibble_dualreg_slave (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_rdy(bus_rdy),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_vld(rd_vld), .rd_data(rd_data), .prim_q(prim_q), .aux_q(aux_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] e, input string tag);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_vld = 1'b0;
  endtask

  task automatic rd_none(input logic [3:0] a, input string tag);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0;
    chk(rd_vld == 1'b0 && rd_data == 4'h0, tag, {rd_vld, rd_data}, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected response actual=%0h expected=none", rd_data);
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prim_q == 12'h0, "R1 prim reset", prim_q, 0);
    chk(aux_q == 24'h0, "R1 aux reset", aux_q, 0);
    chk(rd_vld == 1'b0, "R1 rd_vld reset", rd_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rdy == 1'b1, "R10 ready", bus_rdy, 1);

    // R2 primary writes and back-to-back reads (R10)
    wr(4'h1, 4'h5); wr(4'h2, 4'hA); wr(4'h3, 4'hC);
    chk(prim_q == 12'hCA5, "R2 prim write", prim_q, 12'hCA5);
    rd(4'h1, 4'h5, "R2 read unit0");
    rd(4'h2, 4'hA, "R10 back-to-back unit1");
    rd(4'h3, 4'hC, "R2 read unit2");

    // R3 / R4 nibble auxiliary
    wr(4'hF, 4'h2); wr(4'h2, 4'h7);
    chk(aux_q[15:8] == 8'h07, "R3 aux write unit1", aux_q[15:8], 8'h07);
    chk(prim_q[7:4] == 4'hA, "R3 primary kept", prim_q[7:4], 4'hA);
    rd(4'h2, 4'hA, "R4 back to primary");
    wr(4'hF, 4'h2); rd(4'h2, 4'h7, "R3 aux read unit1");
    wr(4'h2, 4'h4);
    chk(prim_q[7:4] == 4'h4 && aux_q[15:8] == 8'h07, "R4 cleared after one", {prim_q[7:4], aux_q[15:8]}, 12'h407);

    // R5 byte write, low then high
    wr(4'hF, 4'h3); wr(4'h3, 4'h4);
    chk(aux_q[23:16] == 8'h04, "R5 low nibble first", aux_q[23:16], 8'h04);
    wr(4'h3, 4'h9);
    chk(aux_q[23:16] == 8'h94, "R5 high nibble second", aux_q[23:16], 8'h94);
    chk(prim_q[11:8] == 4'hC, "R5 primary kept", prim_q[11:8], 4'hC);
    rd(4'h3, 4'hC, "R5 cleared after byte");

    // R6 byte read, high then low
    wr(4'hF, 4'h3);
    rd(4'h3, 4'h9, "R6 high nibble first");
    rd(4'h3, 4'h4, "R6 low nibble second");
    rd(4'h3, 4'hC, "R6 cleared after byte");

    // R7 cancel by other unit and by unmapped address
    wr(4'hF, 4'h3); wr(4'h2, 4'h1); wr(4'h3, 4'h6);
    chk(prim_q[11:4] == 8'h61 && aux_q[23:16] == 8'h94, "R7 other unit cancels", {prim_q[11:4], aux_q[23:16]}, 16'h6194);
    wr(4'hF, 4'h2);
    rd_none(4'h0, "R9 unmapped read silent");
    wr(4'h2, 4'h8);
    chk(prim_q[7:4] == 4'h8 && aux_q[15:8] == 8'h07, "R7 unmapped cancels", {prim_q[7:4], aux_q[15:8]}, 12'h807);

    // R8 single-register unit ignores redirection
    wr(4'hF, 4'h1); wr(4'h1, 4'h3);
    chk(prim_q[3:0] == 4'h3 && aux_q[7:0] == 8'h0, "R8 single unit primary", {prim_q[3:0], aux_q[7:0]}, 12'h300);
    wr(4'h1, 4'hE);
    chk(prim_q[3:0] == 4'hE, "R8 second access primary", prim_q[3:0], 4'hE);

    // R9 switch read keeps redirection
    wr(4'hF, 4'h2);
    rd_none(4'hF, "R9 switch read silent");
    wr(4'h2, 4'hB);
    chk(aux_q[15:8] == 8'h0B && prim_q[7:4] == 4'h8, "R9 switch read keeps arm", {aux_q[15:8], prim_q[7:4]}, 12'h0B8);

    // R3 re-arm replaces target
    wr(4'hF, 4'h3); wr(4'hF, 4'h2); wr(4'h2, 4'hD);
    chk(aux_q[23:8] == 16'h94_0D, "R3 re-arm replaces target", aux_q[23:8], 16'h940D);
    chk(bus_rdy == 1'b1, "R10 ready after traffic", bus_rdy, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule